// File: doc/BRIEF.md
# Frame-Synchronous Serial Configuration Port

This block is the configuration slave of an imaging sensor. A host writes registers over a three-wire serial link: a serial clock, a serial data line and a load line. It may write at any moment, including while video is streaming. Each accepted write lands in a shadow register. The settings that steer the sensor are held in a separate active bank. The active bank is refreshed from the shadow copy only when the timing generator pulses its frame-boundary strobe, so a frame is never read out with a mix of old and new settings.

A transaction is one burst of the load line. While the load line is high, the host shifts in an 8-bit address and then a 16-bit data word, most significant bit first. Each bit is sampled on a rising serial clock edge. The three serial wires are brought into the system clock domain through two-flop synchronizers. The serial clock must therefore run well below the system clock: each of its high and low phases must last at least three system clock cycles.

The active bank drives these settings: a detector bias code, the gain selection, the output-count mode, the horizontal and vertical scan reversal, four sync-output enables, the integration time, and the window origin and size.

Top module: `cfgport_top`

## Requirements
- R1: While rst is high and after its release, before any frame strobe with a pending write, the outputs hold these defaults: bias_code=0x0800, gain_sel=1, out_mode=2, scan_h_rev=0, scan_v_rev=0, sync_en=0xF, int_time=1000, win_col=0, win_row=0, win_width=1280, win_height=1024.
- R2: The host raises sload and then clocks in 24 bits on rising sclk edges, most significant bit first: address[7:0] followed by data[15:0]. When sload falls, the data is written to the shadow register at that address. The write appears on the outputs after the next frame_tick.
- R3: A write committed between two frame strobes does not change any output until frame_tick is sampled high.
- R4: A burst of sload that carries any bit count other than 24 (for example 23 or 25) writes nothing.
- R5: The register map is: address 0 bias_code, 1 mode, 2 int_time, 3 win_col, 4 win_row, 5 win_width, 6 win_height. A write to address 7 or above changes no register.
- R6: At the clock edge where frame_tick is high, every register with a pending write is copied to its output in that same cycle. When a register is written several times between strobes, the last value wins.
- R7: The mode register fields are: data[1:0] gain_sel, data[3:2] out_mode, data[4] scan_h_rev, data[5] scan_v_rev, data[9:6] sync_en. Bits [15:10] are discarded.
- R8: A frame_tick with no pending write leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idle low |
| sdata | input | 1 | Serial data, sampled on rising sclk |
| sload | input | 1 | Transaction frame, high during a transfer |
| frame_tick | input | 1 | One-cycle frame-boundary strobe |
| bias_code | output | 16 | Active detector bias code |
| gain_sel | output | 2 | Active gain selection |
| out_mode | output | 2 | Active output-count mode |
| scan_h_rev | output | 1 | Active horizontal scan reversal |
| scan_v_rev | output | 1 | Active vertical scan reversal |
| sync_en | output | 4 | Active sync-output enables |
| int_time | output | 16 | Active integration time |
| win_col | output | 16 | Active window start column |
| win_row | output | 16 | Active window start row |
| win_width | output | 16 | Active window width |
| win_height | output | 16 | Active window height |

## Verification
A falling sload reaches the shadow register no more than four system clocks later: two for the synchronizer, one for edge detection and one for the write. The bench waits eight clocks after dropping sload and then samples the outputs, to show that nothing has moved before the strobe. The outputs change at the first rising edge where frame_tick is high. The bench drives the strobe for exactly one clock between falling edges and samples on the falling edge that follows. The expected values come from a register model in the bench that applies the 24-bit rule, the address limit and the mode-field mask.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = ADDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1) + 1;
    localparam int NUM_REGS   = 7;
    localparam int MODE_W     = 10;

    typedef enum logic [ADDR_W-1:0] {
        A_BIAS   = 8'd0,
        A_MODE   = 8'd1,
        A_ITIME  = 8'd2,
        A_COL    = 8'd3,
        A_ROW    = 8'd4,
        A_WIDTH  = 8'd5,
        A_HEIGHT = 8'd6
    } reg_addr_e;

    function automatic int reg_width(input int idx);
        return (idx == int'(A_MODE)) ? MODE_W : DATA_W;
    endfunction

    function automatic int reg_offset(input int idx);
        int off = 0;
        for (int k = 0; k < idx; k++) off += reg_width(k);
        return off;
    endfunction

    localparam int BANK_W = reg_offset(NUM_REGS);

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            int'(A_BIAS):   return 16'h0800;
            int'(A_MODE):   return 16'h03C9;
            int'(A_ITIME):  return 16'd1000;
            int'(A_WIDTH):  return 16'd1280;
            int'(A_HEIGHT): return 16'd1024;
            default:        return 16'h0000;
        endcase
    endfunction

    function automatic logic [BANK_W-1:0] default_bank();
        logic [BANK_W-1:0] v = '0;
        for (int k = 0; k < NUM_REGS; k++)
            for (int b = 0; b < reg_width(k); b++)
                v[reg_offset(k) + b] = reg_default(k)[b];
        return v;
    endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= din;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              s_clk,
    input  logic              s_dat,
    input  logic              s_load,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_BITS);

    logic                  sclk_q, load_q;
    logic                  sclk_rise, load_rise, load_fall;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shreg;

    assign sclk_rise = s_clk & ~sclk_q;
    assign load_rise = s_load & ~load_q;
    assign load_fall = ~s_load & load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            load_q  <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            wr_en   <= 1'b0;
        end else begin
            sclk_q <= s_clk;
            load_q <= s_load;
            wr_en  <= load_fall && (bit_cnt == CNT_GOOD);
            if (load_rise) begin
                bit_cnt <= '0;
            end else if (s_load && sclk_rise) begin
                shreg <= {shreg[FRAME_BITS-2:0], s_dat};
                if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign wr_addr = shreg[FRAME_BITS-1 -: ADDR_W];
    assign wr_data = shreg[DATA_W-1:0];
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_tick,
    output logic [BANK_W-1:0] shadow_flat,
    output logic [BANK_W-1:0] active_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam int W   = reg_width(i);
        localparam int OFF = reg_offset(i);
        localparam logic [W-1:0] DEF = reg_default(i)[W-1:0];

        logic [W-1:0] shadow_q, active_q;
        logic         pending_q;
        logic         hit;

        assign hit = wr_en && (wr_addr == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q  <= DEF;
                active_q  <= DEF;
                pending_q <= 1'b0;
            end else begin
                if (frame_tick && pending_q) active_q <= shadow_q;
                if (hit) shadow_q <= wr_data[W-1:0];
                pending_q <= hit | (pending_q & ~frame_tick);
            end
        end

        assign shadow_flat[OFF +: W] = shadow_q;
        assign active_flat[OFF +: W] = active_q;
    end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk,
    input  logic        sdata,
    input  logic        sload,
    input  logic        frame_tick,
    output logic [15:0] bias_code,
    output logic [1:0]  gain_sel,
    output logic [1:0]  out_mode,
    output logic        scan_h_rev,
    output logic        scan_v_rev,
    output logic [3:0]  sync_en,
    output logic [15:0] int_time,
    output logic [15:0] win_col,
    output logic [15:0] win_row,
    output logic [15:0] win_width,
    output logic [15:0] win_height
);
    localparam int OFF_MODE = reg_offset(int'(A_MODE));

    logic [2:0]        sync_out;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [BANK_W-1:0] shadow_flat;
    logic [BANK_W-1:0] active_flat;

    cfg_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sload, sdata, sclk}),
        .dout (sync_out)
    );

    cfg_serial_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .s_clk   (sync_out[0]),
        .s_dat   (sync_out[1]),
        .s_load  (sync_out[2]),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    cfg_regbank u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_tick  (frame_tick),
        .shadow_flat (shadow_flat),
        .active_flat (active_flat)
    );

    assign bias_code  = active_flat[reg_offset(int'(A_BIAS))   +: DATA_W];
    assign int_time   = active_flat[reg_offset(int'(A_ITIME))  +: DATA_W];
    assign win_col    = active_flat[reg_offset(int'(A_COL))    +: DATA_W];
    assign win_row    = active_flat[reg_offset(int'(A_ROW))    +: DATA_W];
    assign win_width  = active_flat[reg_offset(int'(A_WIDTH))  +: DATA_W];
    assign win_height = active_flat[reg_offset(int'(A_HEIGHT)) +: DATA_W];
    assign gain_sel   = active_flat[OFF_MODE     +: 2];
    assign out_mode   = active_flat[OFF_MODE + 2 +: 2];
    assign scan_h_rev = active_flat[OFF_MODE + 4];
    assign scan_v_rev = active_flat[OFF_MODE + 5];
    assign sync_en    = active_flat[OFF_MODE + 6 +: 4];
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
    import cfgport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BANK_W-1:0] shadow_flat,
    input logic [BANK_W-1:0] active_flat
);
    localparam logic [BANK_W-1:0] DEF_BANK = default_bank();

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            AST_RESET_DEFAULTS: assert (active_flat == DEF_BANK && shadow_flat == DEF_BANK); // R1
        end
    end

    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R2

    AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(active_flat)); // R3

    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= ADDR_W'(NUM_REGS)) |=> $stable(shadow_flat)); // R5

    AST_TICK_TRANSFER: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> (active_flat == $past(shadow_flat))); // R6
endmodule

bind cfgport_top cfgport_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_tick  (frame_tick),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .shadow_flat (shadow_flat),
    .active_flat (active_flat)
);

// File: tb/cfgport_top_test.sv
`timescale 1ns/1ps
module cfgport_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0, frame_tick = 1'b0;
    logic [15:0] bias_code, int_time, win_col, win_row, win_width, win_height;
    logic [1:0]  gain_sel, out_mode;
    logic [3:0]  sync_en;
    logic        scan_h_rev, scan_v_rev;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] m_shadow [7];
    logic [15:0] m_active [7];

    always #10 clk = ~clk;

    cfgport_top uut (
        .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .sload(sload),
        .frame_tick(frame_tick), .bias_code(bias_code), .gain_sel(gain_sel),
        .out_mode(out_mode), .scan_h_rev(scan_h_rev), .scan_v_rev(scan_v_rev),
        .sync_en(sync_en), .int_time(int_time), .win_col(win_col),
        .win_row(win_row), .win_width(win_width), .win_height(win_height)
    );

    function automatic logic [105:0] expected_outs();
        return {m_active[0], m_active[1][1:0], m_active[1][3:2], m_active[1][4],
                m_active[1][5], m_active[1][9:6], m_active[2], m_active[3],
                m_active[4], m_active[5], m_active[6]};
    endfunction

    function automatic logic [105:0] actual_outs();
        return {bias_code, gain_sel, out_mode, scan_h_rev, scan_v_rev, sync_en,
                int_time, win_col, win_row, win_width, win_height};
    endfunction

    task automatic check_outs(input string req);
        logic [105:0] act, exp_v;
        act   = actual_outs();
        exp_v = expected_outs();
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int nbits, input logic [7:0] addr, input logic [15:0] data);
        logic [23:0] word;
        word = {addr, data};
        @(negedge clk);
        sload = 1'b1;
        clks(4);
        for (int i = 0; i < nbits; i++) begin
            sdata = (i < 24) ? word[23-i] : 1'b0;
            clks(4);
            sclk = 1'b1;
            clks(4);
            sclk = 1'b0;
        end
        clks(4);
        sload = 1'b0;
        clks(8);
        if (nbits == 24 && addr < 8'd7) m_shadow[addr] = data;
    endtask

    task automatic tick();
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        for (int k = 0; k < 7; k++) m_active[k] = m_shadow[k];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0]  a;
        logic [15:0] d;
        void'($urandom(32'd4242));
        m_shadow[0] = 16'h0800; m_shadow[1] = 16'h03C9; m_shadow[2] = 16'd1000;
        m_shadow[3] = 16'd0;    m_shadow[4] = 16'd0;    m_shadow[5] = 16'd1280;
        m_shadow[6] = 16'd1024;
        for (int k = 0; k < 7; k++) m_active[k] = m_shadow[k];

        clks(3);
        check_outs("R1 during reset");
        clks(2);
        rst = 1'b0;
        clks(3);
        check_outs("R1 after reset");

        send(24, 8'd2, 16'h1234);
        check_outs("R3 held before tick");
        tick();
        check_outs("R2 int_time write");

        send(24, 8'd1, 16'hFFFF);
        tick();
        check_outs("R7 mode upper bits discarded");
        send(24, 8'd1, 16'h0116);
        tick();
        check_outs("R7 mode fields");

        send(23, 8'd0, 16'hAAAA);
        tick();
        check_outs("R4 23-bit burst");
        send(25, 8'd0, 16'h5555);
        tick();
        check_outs("R4 25-bit burst");

        send(24, 8'd7, 16'hBEEF);
        tick();
        check_outs("R5 address 7");
        send(24, 8'hFF, 16'hBEEF);
        tick();
        check_outs("R5 address 255");

        send(24, 8'd3, 16'h0010);
        send(24, 8'd3, 16'h0020);
        send(24, 8'd6, 16'h0200);
        send(24, 8'd0, 16'hFFFF);
        check_outs("R3 several pending");
        tick();
        check_outs("R6 all pending copied, last wins");

        tick();
        check_outs("R8 idle tick");

        for (int it = 0; it < 40; it++) begin
            a = 8'($urandom_range(0, 8));
            d = 16'($urandom);
            n = ($urandom_range(0, 5) == 0) ? (($urandom_range(0, 1) == 0) ? 23 : 25) : 24;
            send(n, a, d);
            check_outs("R3 random hold");
            if ($urandom_range(0, 2) != 0) begin
                tick();
                check_outs("R2 R6 random transfer");
            end
        end
        tick();
        check_outs("R6 final transfer");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule